// File: doc/BRIEF.md
# Orthogonal 4:1:1 Chroma Nibble Packer

This block turns a pixel stream with full-rate luma and quarter-rate chroma into a narrow output stream. Every pixel brings its own 8-bit luma sample. Once per group of four pixels, the stream also brings one 8-bit U sample and one 8-bit V sample. The block sends the luma straight through. The chroma goes out on a 4-bit nibble bus, two bits of U and two bits of V per pixel, so that by the end of the group all sixteen chroma bits have been sent, highest bits first.

The source marks the first pixel of each group with a group-start strobe. The block captures U and V on that pixel into a holding register, then serializes them over the following pixels. A 2-bit phase index is sent out beside the data, so a receiver can tell which bit pair it is looking at. Pixel-valid gaps stall the sequence without losing place. U and V are signed two's-complement values centred on zero, in either the ±112 range or the ±127 range. The block moves their bits unchanged. Moving chroma onto an orthogonal raster happens upstream; this block only orders and packs bits.

Top module: `yuv411_chroma_packer`

## Requirements
- R1: While reset is high and on the first clock after it, y_out, c_out and phase_out are all zero.
- R2: On a clock where pix_vld is 1, y_out takes y_in on that edge. Luma and chroma of one pixel appear together in the same output cycle.
- R3: A valid pixel with grp_start=1 produces c_out = {U[7],U[6],V[7],V[6]} (bit 3 down to bit 0) and phase_out = 0 on the next cycle, using that pixel's own u_in/v_in.
- R4: The second, third and fourth valid pixels of a group produce phase_out 1, 2 and 3, with c_out equal to {U5,U4,V5,V4}, {U3,U2,V3,V2} and {U1,U0,V1,V0} respectively.
- R5: U and V are captured on the group-start pixel. Changes on u_in/v_in during the rest of the group do not alter the nibbles sent.
- R6: On a clock with pix_vld=0, y_out, c_out and phase_out hold their values and the phase does not advance.
- R7: A valid pixel after phase 3 with no grp_start wraps to phase 0 and resends {U7,U6,V7,V6} of the held values.
- R8: grp_start on a valid pixel in the middle of a group restarts at phase 0 and captures the new U/V.
- R9: grp_start while pix_vld=0 is ignored. The next valid pixel without grp_start continues the current group with the old U/V.
- R10: Negative and extreme chroma codes (for example 0x90 = -112, 0x81 = -127, 0x7F = +127) are sent bit-exact, with no clamping or sign handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_vld | input | 1 | Input pixel is valid on this clock |
| grp_start | input | 1 | This valid pixel opens a four-pixel chroma group |
| y_in | input | 8 | Luma sample |
| u_in | input | 8 | U sample, read on the group-start pixel |
| v_in | input | 8 | V sample, read on the group-start pixel |
| y_out | output | 8 | Registered luma |
| c_out | output | 4 | Chroma nibble: bits 3..2 from U, bits 1..0 from V |
| phase_out | output | 2 | Position of the current nibble in its group, 0..3 |

## Verification
The bench changes u_in and v_in on every pixel after group start. A design that reads chroma live instead of from the holding register would then send mixed bits. It also inserts pix_vld gaps inside a group, some of them with a stray grp_start. A counter that runs on every clock, or a strobe that is not gated by valid, would then skip bit pairs or restart early. Running past the fourth pixel without a new start checks the wrap. A counter that saturated or ran past 3 would show a wrong phase and wrong bits. Asymmetric patterns such as 0xA5/0x3C and negative codes make swapped U/V lanes or reversed bit order show up at the ports.

// File: rtl/yuv411_pkg.sv
package yuv411_pkg;
  // Default geometry of the packer
  localparam int unsigned DEF_LUMA_W  = 8;
  localparam int unsigned DEF_CHROMA_W = 8;
  localparam int unsigned DEF_LANE_BITS = 2;
  localparam int unsigned DEF_PHASES = DEF_CHROMA_W / DEF_LANE_BITS;
endpackage

// File: rtl/yuv411_chroma_hold.sv
module yuv411_chroma_hold #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] u_in,
  input  logic [CW-1:0] v_in,
  output logic [CW-1:0] u_q,
  output logic [CW-1:0] v_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      u_q <= '0;
      v_q <= '0;
    end else if (load) begin
      u_q <= u_in;
      v_q <= v_in;
    end
  end
endmodule

// File: rtl/yuv411_phase_seq.sv
module yuv411_phase_seq #(
  parameter int unsigned PHASES = 4,
  localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          restart,
  output logic [PW-1:0] cur_idx,
  output logic          load
);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0] cnt_q;

  // Index used by the pixel on this clock; a start forces slot zero
  always_comb begin
    cur_idx = restart ? '0 : cnt_q;
    load    = adv && restart;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= (cur_idx == LAST) ? '0 : cur_idx + 1'b1;
    end
  end
endmodule

// File: rtl/yuv411_nibble_mux.sv
module yuv411_nibble_mux #(
  parameter int unsigned CW  = 8,
  parameter int unsigned BPL = 2,
  localparam int unsigned PHASES = CW / BPL,
  localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic [CW-1:0]      u_src,
  input  logic [CW-1:0]      v_src,
  input  logic [PW-1:0]      idx,
  output logic [2*BPL-1:0]   nib
);
  logic [BPL-1:0] u_sl [PHASES];
  logic [BPL-1:0] v_sl [PHASES];

  // Slot k takes the k-th bit pair counted from the MSB end
  for (genvar k = 0; k < PHASES; k++) begin : g_slice
    assign u_sl[k] = u_src[CW-1-k*BPL -: BPL];
    assign v_sl[k] = v_src[CW-1-k*BPL -: BPL];
  end

  always_comb begin
    nib = {u_sl[idx], v_sl[idx]};
  end
endmodule

// File: rtl/yuv411_chroma_packer.sv
module yuv411_chroma_packer #(
  parameter int unsigned YW  = yuv411_pkg::DEF_LUMA_W,
  parameter int unsigned CW  = yuv411_pkg::DEF_CHROMA_W,
  parameter int unsigned BPL = yuv411_pkg::DEF_LANE_BITS,
  localparam int unsigned PHASES = CW / BPL,
  localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1,
  localparam int unsigned NW = 2 * BPL
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_vld,
  input  logic          grp_start,
  input  logic [YW-1:0] y_in,
  input  logic [CW-1:0] u_in,
  input  logic [CW-1:0] v_in,
  output logic [YW-1:0] y_out,
  output logic [NW-1:0] c_out,
  output logic [PW-1:0] phase_out
);
  logic [PW-1:0] cur_idx;
  logic          load;
  logic [CW-1:0] u_q, v_q;
  logic [CW-1:0] u_src, v_src;
  logic [NW-1:0] nib;
  logic          start_now;

  assign start_now = pix_vld && grp_start;

  yuv411_phase_seq #(.PHASES(PHASES)) seq_i (
    .clk(clk), .rst(rst), .adv(pix_vld), .restart(grp_start),
    .cur_idx(cur_idx), .load(load)
  );

  yuv411_chroma_hold #(.CW(CW)) hold_i (
    .clk(clk), .rst(rst), .load(load),
    .u_in(u_in), .v_in(v_in), .u_q(u_q), .v_q(v_q)
  );

  // The start pixel sends from its own inputs; later slots from the hold
  always_comb begin
    u_src = start_now ? u_in : u_q;
    v_src = start_now ? v_in : v_q;
  end

  yuv411_nibble_mux #(.CW(CW), .BPL(BPL)) mux_i (
    .u_src(u_src), .v_src(v_src), .idx(cur_idx), .nib(nib)
  );

  // One output register stage for luma, chroma and phase alike
  always_ff @(posedge clk) begin
    if (rst) begin
      y_out     <= '0;
      c_out     <= '0;
      phase_out <= '0;
    end else if (pix_vld) begin
      y_out     <= y_in;
      c_out     <= nib;
      phase_out <= cur_idx;
    end
  end
endmodule

// File: rtl/yuv411_chroma_packer_chk.sv
module yuv411_chroma_packer_chk #(
  parameter int unsigned YW = 8,
  parameter int unsigned CW = 8,
  parameter int unsigned BPL = 2,
  parameter int unsigned PW = 2,
  parameter int unsigned NW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_vld,
  input logic          grp_start,
  input logic [YW-1:0] y_in,
  input logic [CW-1:0] u_in,
  input logic [CW-1:0] v_in,
  input logic [YW-1:0] y_out,
  input logic [NW-1:0] c_out,
  input logic [PW-1:0] phase_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (y_out == '0 && c_out == '0 && phase_out == '0));

  // R2
  luma_follow_chk: assert property (@(posedge clk) disable iff (rst)
    pix_vld |=> y_out == $past(y_in));

  // R3
  start_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_vld && grp_start) |=>
      (phase_out == '0 &&
       c_out[NW-1 -: BPL] == $past(u_in[CW-1 -: BPL]) &&
       c_out[BPL-1:0] == $past(v_in[CW-1 -: BPL])));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_vld |=> ($stable(y_out) && $stable(c_out) && $stable(phase_out)));

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_vld && !grp_start && phase_out == PW'((CW / BPL) - 1)) |=>
      phase_out == '0);
endmodule

bind yuv411_chroma_packer yuv411_chroma_packer_chk #(
  .YW(YW), .CW(CW), .BPL(BPL), .PW(PW), .NW(NW)
) chk_i (
  .clk(clk), .rst(rst), .pix_vld(pix_vld), .grp_start(grp_start),
  .y_in(y_in), .u_in(u_in), .v_in(v_in),
  .y_out(y_out), .c_out(c_out), .phase_out(phase_out)
);

// File: tb/yuv411_chroma_packer_tb.sv
module yuv411_chroma_packer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_vld = 1'b0;
  logic       grp_start = 1'b0;
  logic [7:0] y_in = '0, u_in = '0, v_in = '0;
  logic [7:0] y_out;
  logic [3:0] c_out;
  logic [1:0] phase_out;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  yuv411_chroma_packer dut_i (
    .clk(clk), .rst(rst), .pix_vld(pix_vld), .grp_start(grp_start),
    .y_in(y_in), .u_in(u_in), .v_in(v_in),
    .y_out(y_out), .c_out(c_out), .phase_out(phase_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected nibble for slot k from the bit-order requirement
  function automatic logic [3:0] exp_nib(input logic [7:0] u, input logic [7:0] v, input int k);
    return {u[7-2*k -: 2], v[7-2*k -: 2]};
  endfunction

  // Drive one clock of input at a falling edge, return at the next falling edge
  task automatic step(input logic vld, input logic st, input logic [7:0] y,
                      input logic [7:0] u, input logic [7:0] v);
    pix_vld = vld; grp_start = st; y_in = y; u_in = u; v_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 y_out", y_out, 0);
    chk("R1 c_out", c_out, 0);
    chk("R1 phase_out", phase_out, 0);
  endtask

  task automatic t_group(input logic [7:0] u, input logic [7:0] v, input logic [7:0] yb, input string tag);
    for (int k = 0; k < 4; k++) begin
      step(1'b1, k == 0, yb + 8'(k), u, v);
      chk({tag, " R2 luma"}, y_out, yb + 8'(k));
      chk({tag, (k == 0) ? " R3 nibble" : " R4 nibble"}, c_out, exp_nib(u, v, k));
      chk({tag, (k == 0) ? " R3 phase" : " R4 phase"}, phase_out, k);
    end
  endtask

  task automatic t_hold_inputs();
    step(1'b1, 1'b1, 8'h10, 8'hA5, 8'h3C);
    for (int k = 1; k < 4; k++) begin
      step(1'b1, 1'b0, 8'h10, 8'h5A ^ 8'(k), 8'hC3 ^ 8'(k));
      chk("R5 held chroma", c_out, exp_nib(8'hA5, 8'h3C, k));
    end
  endtask

  task automatic t_stall();
    step(1'b1, 1'b1, 8'h21, 8'h6B, 8'hD2);
    step(1'b0, 1'b0, 8'hEE, 8'h00, 8'hFF);
    chk("R6 y hold", y_out, 8'h21);
    chk("R6 c hold", c_out, exp_nib(8'h6B, 8'hD2, 0));
    chk("R6 phase hold", phase_out, 0);
    step(1'b0, 1'b0, 8'hEF, 8'h00, 8'hFF);
    step(1'b1, 1'b0, 8'h22, 8'h00, 8'h00);
    chk("R6 resume phase", phase_out, 1);
    chk("R6 resume nibble", c_out, exp_nib(8'h6B, 8'hD2, 1));
    step(1'b1, 1'b0, 8'h23, 8'h00, 8'h00);
    step(1'b1, 1'b0, 8'h24, 8'h00, 8'h00);
    chk("R6 end phase", phase_out, 3);
  endtask

  task automatic t_wrap();
    t_group(8'hC6, 8'h19, 8'h40, "wrap");
    step(1'b1, 1'b0, 8'h50, 8'hFF, 8'hFF);
    chk("R7 wrap phase", phase_out, 0);
    chk("R7 wrap nibble", c_out, exp_nib(8'hC6, 8'h19, 0));
    step(1'b1, 1'b0, 8'h51, 8'hFF, 8'hFF);
    chk("R7 after wrap", c_out, exp_nib(8'hC6, 8'h19, 1));
  endtask

  task automatic t_restart();
    step(1'b1, 1'b1, 8'h60, 8'h33, 8'hCC);
    step(1'b1, 1'b0, 8'h61, 8'h33, 8'hCC);
    step(1'b1, 1'b1, 8'h62, 8'hE4, 8'h1B);
    chk("R8 restart phase", phase_out, 0);
    chk("R8 restart nibble", c_out, exp_nib(8'hE4, 8'h1B, 0));
    step(1'b1, 1'b0, 8'h63, 8'h00, 8'h00);
    chk("R8 new capture", c_out, exp_nib(8'hE4, 8'h1B, 1));
  endtask

  task automatic t_start_no_vld();
    step(1'b1, 1'b1, 8'h70, 8'h96, 8'h69);
    step(1'b0, 1'b1, 8'h71, 8'h0F, 8'hF0);
    chk("R9 stray start phase", phase_out, 0);
    step(1'b1, 1'b0, 8'h72, 8'h0F, 8'hF0);
    chk("R9 continue phase", phase_out, 1);
    chk("R9 old chroma", c_out, exp_nib(8'h96, 8'h69, 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_group(8'hA5, 8'h3C, 8'h80, "basic");
    t_group(8'h90, 8'h81, 8'h01, "R10 neg");
    t_group(8'h7F, 8'h70, 8'hF0, "R10 pos");
    t_hold_inputs();
    t_stall();
    t_wrap();
    t_restart();
    t_start_no_vld();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule